// File: doc/BRIEF.md
# Three-Port Parallel I/O with Interrupt-Line Readback

This block sits on an 8-bit processor bus and provides three byte-wide general-purpose ports. The processor writes a data register, and the byte goes into an output latch. The latch is presented on the port's output pins. A matching enable vector tells the pad ring which of those pins to drive. Ports B and C each have a direction register, where a 1 bit makes the pin an input. Port A has no direction register, and all of its pins are driven. A data-register read returns the pin levels after a two-flop synchronizer, not the contents of the latch.

The top two bits of port C also serve two active-low external interrupt lines. On a read, bit 7 gives the synchronized level of line 2 and bit 6 gives the level of line 1. On a write, a 1 in bit 7 or bit 6 clears that line's falling-edge latch. Each line has an interrupt request output. A per-line mode input selects the edge latch or the live level as the source of that request.

Top module: `pio_three_port`

## Requirements
- R1: After reset, both direction registers read 0xFF, the port B and port C output enables are all 0, every output latch is 0 and both interrupt requests are 0.
- R2: A direction bit of 1 makes its pin an input (enable 0), and a bit of 0 makes it an output (enable 1). A direction register reads back the last value written to it.
- R3: A write to a data register stores the byte, and the byte appears on that port's output pins after the write clock edge.
- R4: A data-register read returns the pin levels sampled two clock edges earlier, not the stored output byte.
- R5: A read of port C data returns the synchronized level of interrupt line 2 in bit 7 and of line 1 in bit 6. Bits 5..0 carry the port C pins.
- R6: In edge mode (mode bit 1), a falling edge on an interrupt line sets its latch three clock edges later. The latch drives the request high and holds it after the line rises again.
- R7: A port C data write with bit 7 set clears the line 2 latch, and with bit 6 set it clears the line 1 latch. A 0 in either bit leaves that latch set.
- R8: When a falling edge is detected in the same cycle as a clear write, the latch stays set.
- R9: In level mode (mode bit 0), a request is high while its synchronized line is low.
- R10: The registers decode at address 0xEE (A data), 0xE4 (B direction), 0xE5 (B data), 0xDD (C direction) and 0xDE (C data). Any other address reads 0, and a write to it changes no output.
- R11: The port A output enables are always all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Low address byte |
| busWdata | input | 8 | Write data |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRdata | output | 8 | Read data for busAddr (combinational) |
| portAIn | input | 8 | Port A pin levels |
| portAOut | output | 8 | Port A output latch |
| portAOe | output | 8 | Port A drive enables |
| portBIn | input | 8 | Port B pin levels |
| portBOut | output | 8 | Port B output latch |
| portBOe | output | 8 | Port B drive enables |
| portCIn | input | 8 | Port C pin levels |
| portCOut | output | 8 | Port C output latch |
| portCOe | output | 8 | Port C drive enables |
| intLineN | input | 2 | Active-low interrupt lines (bit 1 = line 2) |
| edgeMode | input | 2 | Per-line request source: 1 = edge latch, 0 = level |
| intReq | output | 2 | Interrupt requests, active high |

## Verification
If a latch or direction register is corrupted, the wrong value shows up on the output or enable pins at the next negative clock phase after the write, and it shows up again when the register is read back. If the synchronizer stage count is wrong, pin readback or the raw interrupt bits change one cycle too early or too late, and the bench samples exactly two edges after a pin change to catch this. A faulty edge latch shows on intReq in one of three ways: the request does not hold after the line rises, it survives a write-one clear, or it drops when a new edge coincides with a clear.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef struct packed {
    logic       wrAData;
    logic       wrBDir;
    logic       wrBData;
    logic       wrCDir;
    logic       wrCData;
    logic [1:0] clrEdge;  // [1] = line 2, [0] = line 1
  } pioStrobes_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_A_DATA,
    SEL_B_DIR,
    SEL_B_DATA,
    SEL_C_DIR,
    SEL_C_DATA
  } pioSel_t;

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int            W         = 8,
  parameter int            STAGES    = 2,
  parameter logic [W-1:0]  RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] dOut
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RESET_VAL;
    end else begin
      stage[0] <= dIn;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dOut = stage[STAGES-1];
endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] A_DATA   = 8'hEE,
  parameter logic [ADDR_W-1:0] B_DIR    = 8'hE4,
  parameter logic [ADDR_W-1:0] B_DATA   = 8'hE5,
  parameter logic [ADDR_W-1:0] C_DIR    = 8'hDD,
  parameter logic [ADDR_W-1:0] C_DATA   = 8'hDE
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWr,
  output pioStrobes_t       strobes,
  output pioSel_t           rdSel
);
  localparam int HI_CLR_BIT = DATA_W - 1;
  localparam int LO_CLR_BIT = DATA_W - 2;

  always_comb begin
    unique case (busAddr)
      A_DATA:  rdSel = SEL_A_DATA;
      B_DIR:   rdSel = SEL_B_DIR;
      B_DATA:  rdSel = SEL_B_DATA;
      C_DIR:   rdSel = SEL_C_DIR;
      C_DATA:  rdSel = SEL_C_DATA;
      default: rdSel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobes            = '0;
    strobes.wrAData    = busWr && (rdSel == SEL_A_DATA);
    strobes.wrBDir     = busWr && (rdSel == SEL_B_DIR);
    strobes.wrBData    = busWr && (rdSel == SEL_B_DATA);
    strobes.wrCDir     = busWr && (rdSel == SEL_C_DIR);
    strobes.wrCData    = busWr && (rdSel == SEL_C_DATA);
    strobes.clrEdge[1] = strobes.wrCData && busWdata[HI_CLR_BIT];
    strobes.clrEdge[0] = strobes.wrCData && busWdata[LO_CLR_BIT];
  end
endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_INT  = 2,
  parameter int SYNC_LEN = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  pioStrobes_t         strobes,
  input  pioSel_t             rdSel,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [DATA_W-1:0]   portAIn,
  output logic [DATA_W-1:0]   portAOut,
  output logic [DATA_W-1:0]   portAOe,
  input  logic [DATA_W-1:0]   portBIn,
  output logic [DATA_W-1:0]   portBOut,
  output logic [DATA_W-1:0]   portBOe,
  input  logic [DATA_W-1:0]   portCIn,
  output logic [DATA_W-1:0]   portCOut,
  output logic [DATA_W-1:0]   portCOe,
  input  logic [NUM_INT-1:0]  intLineN,
  input  logic [NUM_INT-1:0]  edgeMode,
  output logic [NUM_INT-1:0]  intReq
);
  localparam int PIN_W = 3 * DATA_W;

  logic [DATA_W-1:0]  dataA, dataB, dataC, dirB, dirC;
  logic [DATA_W-1:0]  syncA, syncB, syncC;
  logic [NUM_INT-1:0] intSync, intPrev, edgeLatch;
  logic [NUM_INT-1:0] clrVec;

  pio_sync #(.W(PIN_W), .STAGES(SYNC_LEN), .RESET_VAL('0)) u_pinSync (
    .clk(clk), .rst_n(rst_n),
    .dIn({portCIn, portBIn, portAIn}),
    .dOut({syncC, syncB, syncA})
  );

  pio_sync #(.W(NUM_INT), .STAGES(SYNC_LEN), .RESET_VAL('1)) u_intSync (
    .clk(clk), .rst_n(rst_n),
    .dIn(intLineN),
    .dOut(intSync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataA <= '0;
      dataB <= '0;
      dataC <= '0;
      dirB  <= '1;
      dirC  <= '1;
    end else begin
      if (strobes.wrAData) dataA <= busWdata;
      if (strobes.wrBData) dataB <= busWdata;
      if (strobes.wrCData) dataC <= busWdata;
      if (strobes.wrBDir)  dirB  <= busWdata;
      if (strobes.wrCDir)  dirC  <= busWdata;
    end
  end

  assign clrVec = strobes.clrEdge[NUM_INT-1:0];

  generate
    for (genvar g = 0; g < NUM_INT; g++) begin : gEdge
      logic fallSeen;
      assign fallSeen = intPrev[g] & ~intSync[g];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          intPrev[g]   <= 1'b1;
          edgeLatch[g] <= 1'b0;
        end else begin
          intPrev[g]   <= intSync[g];
          // a new edge wins over a simultaneous software clear
          edgeLatch[g] <= fallSeen | (edgeLatch[g] & ~clrVec[g]);
        end
      end

      assign intReq[g] = edgeMode[g] ? edgeLatch[g] : ~intSync[g];
    end
  endgenerate

  assign portAOut = dataA;
  assign portAOe  = '1;
  assign portBOut = dataB;
  assign portBOe  = ~dirB;
  assign portCOut = dataC;
  assign portCOe  = ~dirC;

  always_comb begin
    unique case (rdSel)
      SEL_A_DATA: busRdata = syncA;
      SEL_B_DIR:  busRdata = dirB;
      SEL_B_DATA: busRdata = syncB;
      SEL_C_DIR:  busRdata = dirC;
      SEL_C_DATA: begin
        busRdata = syncC;
        busRdata[DATA_W-1 -: NUM_INT] = intSync;
      end
      default:    busRdata = '0;
    endcase
  end
endmodule

// File: rtl/pio_three_port.sv
module pio_three_port
  import pio_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 8,
  parameter int          NUM_INT  = 2,
  parameter int          SYNC_LEN = 2,
  parameter logic [7:0]  A_DATA   = 8'hEE,
  parameter logic [7:0]  B_DIR    = 8'hE4,
  parameter logic [7:0]  B_DATA   = 8'hE5,
  parameter logic [7:0]  C_DIR    = 8'hDD,
  parameter logic [7:0]  C_DATA   = 8'hDE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic                busWr,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [DATA_W-1:0]   portAIn,
  output logic [DATA_W-1:0]   portAOut,
  output logic [DATA_W-1:0]   portAOe,
  input  logic [DATA_W-1:0]   portBIn,
  output logic [DATA_W-1:0]   portBOut,
  output logic [DATA_W-1:0]   portBOe,
  input  logic [DATA_W-1:0]   portCIn,
  output logic [DATA_W-1:0]   portCOut,
  output logic [DATA_W-1:0]   portCOe,
  input  logic [NUM_INT-1:0]  intLineN,
  input  logic [NUM_INT-1:0]  edgeMode,
  output logic [NUM_INT-1:0]  intReq
);
  pioStrobes_t strobes;
  pioSel_t     rdSel;

  pio_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .A_DATA(A_DATA), .B_DIR(B_DIR), .B_DATA(B_DATA),
    .C_DIR(C_DIR), .C_DATA(C_DATA)
  ) u_ctrl (
    .busAddr(busAddr), .busWdata(busWdata), .busWr(busWr),
    .strobes(strobes), .rdSel(rdSel)
  );

  pio_datapath #(.DATA_W(DATA_W), .NUM_INT(NUM_INT), .SYNC_LEN(SYNC_LEN)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .strobes(strobes), .rdSel(rdSel),
    .busWdata(busWdata), .busRdata(busRdata),
    .portAIn(portAIn), .portAOut(portAOut), .portAOe(portAOe),
    .portBIn(portBIn), .portBOut(portBOut), .portBOe(portBOe),
    .portCIn(portCIn), .portCOut(portCOut), .portCOe(portCOe),
    .intLineN(intLineN), .edgeMode(edgeMode), .intReq(intReq)
  );
endmodule

// File: rtl/pio_three_port_chk.sv
module pio_three_port_chk #(
  parameter logic [7:0] A_DATA = 8'hEE,
  parameter logic [7:0] B_DIR  = 8'hE4,
  parameter logic [7:0] B_DATA = 8'hE5,
  parameter logic [7:0] C_DIR  = 8'hDD,
  parameter logic [7:0] C_DATA = 8'hDE
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] busAddr,
  input logic [7:0] busWdata,
  input logic       busWr,
  input logic [7:0] busRdata,
  input logic [7:0] portAOut,
  input logic [7:0] portBOe,
  input logic [7:0] portCOut,
  input logic [7:0] portCOe,
  input logic [1:0] edgeMode,
  input logic [1:0] intReq
);
  logic wrBDir, wrCData, clrLine1, mapped;
  assign wrBDir   = busWr && (busAddr == B_DIR);
  assign wrCData  = busWr && (busAddr == C_DATA);
  assign clrLine1 = wrCData && busWdata[6];
  assign mapped   = (busAddr == A_DATA) || (busAddr == B_DIR) || (busAddr == B_DATA) ||
                    (busAddr == C_DIR)  || (busAddr == C_DATA);

  p_bdir_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrBDir |=> (portBOe == ~$past(busWdata)));

  p_cdir_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == C_DIR) |-> (busRdata == ~portCOe));

  p_cdata_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrCData |=> (portCOut == $past(busWdata)));

  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (edgeMode[0] && intReq[0] && !clrLine1) |=> (!edgeMode[0] || intReq[0]));

  p_unmapped_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (busRdata == 8'h00));

  p_adata_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busWr && (busAddr == A_DATA)) |=> $stable(portAOut));
endmodule

bind pio_three_port pio_three_port_chk #(
  .A_DATA(A_DATA), .B_DIR(B_DIR), .B_DATA(B_DATA), .C_DIR(C_DIR), .C_DATA(C_DATA)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWdata(busWdata), .busWr(busWr),
  .busRdata(busRdata), .portAOut(portAOut), .portBOe(portBOe), .portCOut(portCOut),
  .portCOe(portCOe), .edgeMode(edgeMode), .intReq(intReq)
);

// File: tb/pio_three_port_test.sv
module pio_three_port_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] busAddr = 0, busWdata = 0;
  logic       busWr = 0;
  logic [7:0] busRdata;
  logic [7:0] portAIn = 0, portBIn = 0, portCIn = 0;
  logic [7:0] portAOut, portAOe, portBOut, portBOe, portCOut, portCOe;
  logic [1:0] intLineN = 2'b11, edgeMode = 2'b11, intReq;

  int checks = 0, errors = 0;
  logic [7:0] mA = 0, mB = 0, mC = 0, mDirB = 8'hFF, mDirC = 8'hFF;

  always #5 clk = ~clk;

  pio_three_port uut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1;
    @(posedge clk); @(negedge clk);
    busWr = 0;
    case (a)
      8'hEE: mA = d;
      8'hE4: mDirB = d;
      8'hE5: mB = d;
      8'hDD: mDirC = d;
      8'hDE: mC = d;
      default: ;
    endcase
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    busAddr = a; #1; d = busRdata;
  endtask

  function automatic logic [7:0] expC(logic [7:0] pins, logic [1:0] lines);
    return {lines[1], lines[0], pins[5:0]};
  endfunction

  task automatic chkOutputs(string tagOut);
    chk({tagOut, " A out"}, portAOut, mA);
    chk({tagOut, " B out"}, portBOut, mB);
    chk({tagOut, " C out"}, portCOut, mC);
    chk("R2 B oe", portBOe, ~mDirB);
    chk("R2 C oe", portCOe, ~mDirC);
    chk("R11 A oe", portAOe, 8'hFF);
  endtask

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'h5eed_0189));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(8'hE4, r); chk("R1 B dir", r, 8'hFF);
    rd(8'hDD, r); chk("R1 C dir", r, 8'hFF);
    chk("R1 B oe", portBOe, 8'h00);
    chk("R1 C oe", portCOe, 8'h00);
    chk("R1 A out", portAOut, 8'h00);
    chk("R1 intReq", {6'b0, intReq}, 8'h00);

    // R3 / R4 directed: latch differs from pins
    wr(8'hE5, 8'hA5);
    portBIn = 8'h3C;
    rd(8'hE5, r); chk("R4 before sync", r, 8'h00);
    settle(2);
    rd(8'hE5, r); chk("R4 B pins", r, 8'h3C);
    chk("R3 B out", portBOut, 8'hA5);

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 6);
      logic [7:0] d = 8'($urandom);
      case (op)
        0: wr(8'hEE, d);
        1: wr(8'hE4, d);
        2: wr(8'hE5, d);
        3: wr(8'hDD, d);
        4: wr(8'hDE, d);
        5: begin
          logic [7:0] ua = 8'($urandom);
          if (ua == 8'hEE || ua == 8'hE4 || ua == 8'hE5 || ua == 8'hDD || ua == 8'hDE) ua = 8'h00;
          wr(ua, d);
          rd(ua, r); chk("R10 unmapped read", r, 8'h00);
        end
        default: begin
          portAIn = 8'($urandom); portBIn = 8'($urandom); portCIn = 8'($urandom);
          settle(2);
          rd(8'hEE, r); chk("R4 A pins", r, portAIn);
          rd(8'hE5, r); chk("R4 B pins", r, portBIn);
          rd(8'hDE, r); chk("R5 C read", r, expC(portCIn, intLineN));
        end
      endcase
      chkOutputs(op == 5 ? "R10" : "R3");
      rd(8'hE4, r); chk("R2 B dir read", r, mDirB);
      rd(8'hDD, r); chk("R2 C dir read", r, mDirC);
    end

    // R6 edge sets and holds
    edgeMode = 2'b11;
    wr(8'hDE, 8'hC0);
    chk("R6 idle", {6'b0, intReq}, 8'h00);
    intLineN = 2'b10;
    settle(2);
    rd(8'hDE, r); chk("R5 line1 low", r, expC(portCIn, 2'b10));
    chk("R6 not yet", {6'b0, intReq}, 8'h00);
    settle(1);
    chk("R6 set", {6'b0, intReq}, 8'h01);
    intLineN = 2'b11;
    settle(4);
    chk("R6 hold", {6'b0, intReq}, 8'h01);
    // R7 write zero no effect, write one clears
    wr(8'hDE, 8'h80);
    chk("R7 zero keeps line1", {6'b0, intReq}, 8'h01);
    wr(8'hDE, 8'h40);
    chk("R7 clear line1", {6'b0, intReq}, 8'h00);

    // R8 clear coincides with new edge on line 2
    intLineN = 2'b01; settle(4);
    chk("R6 line2 set", {6'b0, intReq}, 8'h02);
    intLineN = 2'b11; settle(4);
    intLineN = 2'b01;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(8'hDE, 8'h80);
    chk("R8 edge beats clear", {6'b0, intReq}, 8'h02);
    wr(8'hDE, 8'h80);
    chk("R7 clear line2", {6'b0, intReq}, 8'h00);
    rd(8'hDE, r); chk("R5 line2 low", r, expC(portCIn, 2'b01));

    // R9 level mode
    edgeMode = 2'b00;
    intLineN = 2'b11; settle(2);
    chk("R9 level high", {6'b0, intReq}, 8'h00);
    intLineN = 2'b10; settle(2);
    chk("R9 level low", {6'b0, intReq}, 8'h01);
    intLineN = 2'b11; settle(2);
    chk("R9 level release", {6'b0, intReq}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule